// File: doc/BRIEF.md
# Legacy Region and DRAM Row Decoder

This block sits on the address path of a memory controller. For each physical address and read/write flag it decides, combinationally, whether the access is served by DRAM or forwarded to memory-mapped I/O. When it is served by DRAM, the block also names the DRAM row that holds the address. The routing rules come from a small configuration store, which is loaded through a byte-wide register write port.

The configuration has three parts. Thirteen two-bit attribute fields cover the legacy window 0xC0000–0xFFFFF, and each field routes reads and writes separately. Eight cumulative row-limit bytes give the top of each row in 8 MB units. A two-bit code can cut a fixed hole out of DRAM. A change to the configuration takes effect from the clock edge that stores it. The outputs follow the address inputs with no register between them.

Top module: `mem_route_decoder`

## Requirements
- R1: After reset every configuration byte is zero, so every address gives `dram_hit`=0, `miss`=1 and `row_idx`=0.
- R2: An attribute field's bit 0 sends reads to DRAM and its bit 1 sends writes to DRAM: 00 sends both to I/O, 01 is read-only, 10 is write-only and 11 sends both to DRAM.
- R3: Field placement: 0xF0000–0xFFFFF uses bits [5:4] of config index 0. The 16 KB segment s (0..11) that starts at 0xC0000+s·0x4000 uses config index 1+s/2, in bits [1:0] when s is even and in bits [5:4] when s is odd.
- R4: An address outside 0xC0000–0xFFFFF and outside an enabled hole goes to DRAM for both reads and writes whenever a row covers it.
- R5: `row_idx` is the lowest row i whose limit (config index 8+i) multiplied by 8 MB is greater than the address.
- R6: When no limit exceeds the address, `miss`=1, `dram_hit`=0 and `row_idx`=0.
- R7: A row whose limit equals the limit of the row below it is empty and is never reported.
- R8: Hole code 01 blocks 0x80000–0x9FFFF and hole code 10 blocks 0xF00000–0xFFFFFF. Neither hole blocks any address outside its range. An address inside an enabled hole never gives `dram_hit`. The hole code is held in bits [1:0] of config index 16.
- R9: Hole code 11 behaves as no hole.
- R10: A write with `cfg_we`=1 stores `cfg_wdata` at `cfg_idx` on the clock edge, and the outputs use the new value from that edge on. Writes to indices 7 and 17–31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Configuration byte index |
| cfg_wdata | input | 8 | Configuration write data |
| acc_addr | input | 32 | Physical address of the access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| dram_hit | output | 1 | Access is served by DRAM |
| row_idx | output | 3 | Selected DRAM row, valid when not `miss` |
| miss | output | 1 | No row covers the address |

## Verification
The main test uses one configuration with uneven row limits, an empty row, and read-only, write-only, open and closed segments. Each kind of segment is probed at its first and last byte with both reads and writes. This distinguishes a swapped read/write bit or a wrong field half from a correct decode. Row probes land on the last byte below each limit and on the limit itself, which separates a strict compare from a non-strict one and shows whether an empty row is skipped. Directed tests then enable each hole code at the edges of its range, rewrite the lowest row limit to zero, and send writes to unmapped indices, each followed by a check of the outputs those writes could disturb.

// File: rtl/mrd_pkg.sv
// Package: shared encodings and configuration index map for the decoder.
// Assumes: byte-wide configuration port with a 5-bit index.
package mrd_pkg;
    // Attribute field: bit 0 routes reads to DRAM, bit 1 routes writes to DRAM.
    typedef enum logic [1:0] {
        ATTR_OFF = 2'b00,
        ATTR_RD  = 2'b01,
        ATTR_WR  = 2'b10,
        ATTR_RW  = 2'b11
    } attr_e;

    // Fixed-hole selection code.
    typedef enum logic [1:0] {
        HOLE_NONE = 2'b00,
        HOLE_LOW  = 2'b01,
        HOLE_HIGH = 2'b10,
        HOLE_RSVD = 2'b11
    } hole_e;

    localparam int CFG_IDX_W     = 5;
    localparam int CFG_DATA_W    = 8;
    localparam int ATTR_BYTES    = 7;
    localparam int CFG_ATTR_BASE = 0;
    localparam int CFG_BND_BASE  = 8;
    localparam int CFG_HOLE_IDX  = 16;
endpackage

// File: rtl/mrd_cfg_regs.sv
// Module: configuration store for attributes, row limits and the hole code.
// Assumes: one write per cycle; unmapped indices are dropped silently.
module mrd_cfg_regs
    import mrd_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int BND_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [CFG_IDX_W-1:0]                  cfg_idx,
    input  logic [CFG_DATA_W-1:0]                 cfg_wdata,
    output logic [ATTR_BYTES-1:0][CFG_DATA_W-1:0] attr_q,
    output logic [ROWS-1:0][BND_W-1:0]            bnd_q,
    output hole_e                                 hole_q
);
    genvar gi;

    // Attribute bytes, one register per index.
    generate
        for (gi = 0; gi < ATTR_BYTES; gi++) begin : g_attr
            // Store an attribute byte when its index is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    attr_q[gi] <= '0;
                else if (cfg_we && cfg_idx == CFG_IDX_W'(CFG_ATTR_BASE + gi))
                    attr_q[gi] <= cfg_wdata;
            end
        end

        for (gi = 0; gi < ROWS; gi++) begin : g_bnd
            // Store a row limit when its index is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bnd_q[gi] <= '0;
                else if (cfg_we && cfg_idx == CFG_IDX_W'(CFG_BND_BASE + gi))
                    bnd_q[gi] <= cfg_wdata[BND_W-1:0];
            end
        end
    endgenerate

    // Store the hole code from the low two bits of its index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hole_q <= HOLE_NONE;
        else if (cfg_we && cfg_idx == CFG_IDX_W'(CFG_HOLE_IDX))
            hole_q <= hole_e'(cfg_wdata[1:0]);
    end

    logic stray_idx;
    assign stray_idx = (cfg_idx >= CFG_IDX_W'(CFG_ATTR_BASE + ATTR_BYTES) &&
                        cfg_idx <  CFG_IDX_W'(CFG_BND_BASE)) ||
                       (cfg_idx >= CFG_IDX_W'(CFG_BND_BASE + ROWS) &&
                        cfg_idx != CFG_IDX_W'(CFG_HOLE_IDX));

    a_r10_limit_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_idx == CFG_IDX_W'(CFG_BND_BASE) |=> bnd_q[0] == $past(cfg_wdata[BND_W-1:0]));

    a_r10_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && stray_idx |=> $stable(bnd_q) && $stable(attr_q) && $stable(hole_q));
endmodule

// File: rtl/mrd_legacy_route.sv
// Module: finds the attribute field for a legacy-window address and applies it.
// Assumes: the window is 0xC0000-0xFFFFF; outside it the result is unused.
module mrd_legacy_route
    import mrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]                     addr,
    input  logic                                  is_write,
    input  logic [ATTR_BYTES-1:0][CFG_DATA_W-1:0] attr_q,
    output logic                                  in_legacy,
    output logic                                  allow
);
    logic       in_bios;
    logic [3:0] seg;
    logic [2:0] byte_sel;
    logic       upper_half;
    attr_e      field;

    // Window and segment decode.
    always_comb begin
        in_legacy  = (addr[ADDR_W-1:20] == '0) && (addr[19:18] == 2'b11);
        in_bios    = (addr[17:16] == 2'b11);
        seg        = addr[17:14];
        byte_sel   = in_bios ? 3'd0 : 3'd1 + {1'b0, seg[3:1]};
        upper_half = in_bios ? 1'b1 : seg[0];
    end

    // Pick the field half and apply the read or write permission bit.
    always_comb begin
        field = upper_half ? attr_e'(attr_q[byte_sel][5:4])
                           : attr_e'(attr_q[byte_sel][1:0]);
        allow = is_write ? field[1] : field[0];
    end
endmodule

// File: rtl/mrd_hole_check.sv
// Module: reports whether an address falls inside the enabled fixed hole.
// Assumes: ADDR_W is above 24, so both hole ranges fit.
module mrd_hole_check
    import mrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  hole_e             hole_q,
    output logic              in_hole
);
    logic in_low, in_high;

    // Range compares for both holes, then selection by the code.
    always_comb begin
        in_low  = addr[ADDR_W-1:17] == (ADDR_W-17)'(4);
        in_high = addr[ADDR_W-1:20] == (ADDR_W-20)'(15);
        unique case (hole_q)
            HOLE_LOW:  in_hole = in_low;
            HOLE_HIGH: in_hole = in_high;
            default:   in_hole = 1'b0;
        endcase
    end

    a_r9_reserved_open: assert property (@(posedge clk) disable iff (!rst_n)
        hole_q == HOLE_RSVD |-> !in_hole);
endmodule

// File: rtl/mrd_row_find.sv
// Module: priority search for the lowest row whose limit lies above the address.
// Assumes: limits are in units of 2**ROW_SHIFT bytes and ADDR_W-ROW_SHIFT >= BND_W.
module mrd_row_find #(
    parameter int ADDR_W    = 32,
    parameter int ROWS      = 8,
    parameter int BND_W     = 8,
    parameter int ROW_SHIFT = 23,
    localparam int ROW_W    = $clog2(ROWS),
    localparam int UP_W     = ADDR_W - ROW_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ROWS-1:0][BND_W-1:0] bnd_q,
    output logic [ROW_W-1:0]           row,
    output logic                       in_range
);
    logic [UP_W-1:0] unit_addr;
    logic [ROWS-1:0] below;
    genvar gi;

    assign unit_addr = addr[ADDR_W-1:ROW_SHIFT];

    // One comparator per row: the address sits under that row's limit.
    generate
        for (gi = 0; gi < ROWS; gi++) begin : g_cmp
            assign below[gi] = unit_addr < UP_W'(bnd_q[gi]);
        end
    endgenerate

    // Lowest set comparator wins; scanning downward lets low rows overwrite.
    always_comb begin
        row = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (below[i]) row = ROW_W'(i);
        end
        in_range = |below;
    end

    a_r5_row_covers: assert property (@(posedge clk) disable iff (!rst_n)
        in_range |-> unit_addr < UP_W'(bnd_q[row]));

    a_r5_row_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        in_range && row != '0 |-> unit_addr >= UP_W'(bnd_q[row - 1'b1]));

    a_r7_nonempty_row: assert property (@(posedge clk) disable iff (!rst_n)
        in_range && row != '0 |-> bnd_q[row] != bnd_q[row - 1'b1]);

    a_r6_miss_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> row == '0);
endmodule

// File: rtl/mem_route_decoder.sv
// Module: top of the legacy-region and DRAM-row decoder.
// Assumes: outputs are combinational in the address; config is registered.
module mem_route_decoder
    import mrd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ROWS      = 8,
    parameter int BND_W     = 8,
    parameter int ROW_SHIFT = 23,
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_IDX_W-1:0]  cfg_idx,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_write,
    output logic                  dram_hit,
    output logic [ROW_W-1:0]      row_idx,
    output logic                  miss
);
    logic [ATTR_BYTES-1:0][CFG_DATA_W-1:0] attr_q;
    logic [ROWS-1:0][BND_W-1:0]            bnd_q;
    hole_e                                 hole_q;
    logic                                  in_legacy, allow, in_hole, in_range;
    logic [ROW_W-1:0]                      row;

    mrd_cfg_regs #(.ROWS(ROWS), .BND_W(BND_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .attr_q(attr_q), .bnd_q(bnd_q), .hole_q(hole_q)
    );

    mrd_legacy_route #(.ADDR_W(ADDR_W)) u_legacy (
        .addr(acc_addr), .is_write(acc_write), .attr_q(attr_q),
        .in_legacy(in_legacy), .allow(allow)
    );

    mrd_hole_check #(.ADDR_W(ADDR_W)) u_hole (
        .clk(clk), .rst_n(rst_n), .addr(acc_addr), .hole_q(hole_q), .in_hole(in_hole)
    );

    mrd_row_find #(.ADDR_W(ADDR_W), .ROWS(ROWS), .BND_W(BND_W), .ROW_SHIFT(ROW_SHIFT)) u_rows (
        .clk(clk), .rst_n(rst_n), .addr(acc_addr), .bnd_q(bnd_q),
        .row(row), .in_range(in_range)
    );

    // Merge routing, hole and row coverage into the outputs.
    always_comb begin
        dram_hit = in_range && !in_hole && (!in_legacy || allow);
        miss     = !in_range;
        row_idx  = row;
    end

    a_r6_miss_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> !dram_hit);

    a_r8_hole_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        in_hole |-> !dram_hit);

    a_r4_plain_hits: assert property (@(posedge clk) disable iff (!rst_n)
        !in_legacy && !in_hole && !miss |-> dram_hit);

    a_r2_denied_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        in_legacy && !allow |-> !dram_hit);
endmodule

// File: tb/mem_route_decoder_bench.sv
module mem_route_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        dram_hit;
    logic [2:0]  row_idx;
    logic        miss;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_route_decoder u_mem_route_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
        .dram_hit(dram_hit), .row_idx(row_idx), .miss(miss)
    );

    // {addr, write, exp_hit, exp_row, exp_miss}
    // Config: limits 2,2,4,5,5,5,5,8; F area RW; C0000 RO; C4000 WO; C8000 RW; rest off.
    localparam logic [37:0] VECS [NVEC] = '{
        {32'h0000_1000, 1'b0, 1'b1, 3'd0, 1'b0},  // R5 row 0
        {32'h00FF_FFFC, 1'b1, 1'b1, 3'd0, 1'b0},  // R4 write outside window
        {32'h0100_0000, 1'b0, 1'b1, 3'd2, 1'b0},  // R7 row 1 empty, skipped
        {32'h027F_FFFF, 1'b0, 1'b1, 3'd3, 1'b0},  // R5 just under limit 5
        {32'h0280_0000, 1'b0, 1'b1, 3'd7, 1'b0},  // R7 rows 4..6 empty
        {32'h03FF_FFFF, 1'b1, 1'b1, 3'd7, 1'b0},  // R5 top byte of last row
        {32'h0400_0000, 1'b0, 1'b0, 3'd0, 1'b1},  // R6 at last limit
        {32'hFFFF_FFFF, 1'b0, 1'b0, 3'd0, 1'b1},  // R6 top of space
        {32'h000F_0000, 1'b0, 1'b1, 3'd0, 1'b0},  // R3 F area read
        {32'h000F_FFFF, 1'b1, 1'b1, 3'd0, 1'b0},  // R3 F area write
        {32'h000C_0000, 1'b0, 1'b1, 3'd0, 1'b0},  // R2 read-only read
        {32'h000C_3FFF, 1'b1, 1'b0, 3'd0, 1'b0},  // R2 read-only write
        {32'h000C_4000, 1'b0, 1'b0, 3'd0, 1'b0},  // R2 write-only read
        {32'h000C_7FFF, 1'b1, 1'b1, 3'd0, 1'b0},  // R2 write-only write
        {32'h000C_8000, 1'b1, 1'b1, 3'd0, 1'b0},  // R3 seg 2 in low half
        {32'h000C_C000, 1'b0, 1'b0, 3'd0, 1'b0},  // R3 seg 3 in high half, off
        {32'h000D_0000, 1'b1, 1'b0, 3'd0, 1'b0},  // R2 off segment
        {32'h000E_FFFF, 1'b0, 1'b0, 3'd0, 1'b0},  // R3 last segment off
        {32'h000B_FFFF, 1'b0, 1'b1, 3'd0, 1'b0},  // R4 just below window
        {32'h0010_0000, 1'b1, 1'b1, 3'd0, 1'b0},  // R4 just above window
        {32'h0008_0000, 1'b0, 1'b1, 3'd0, 1'b0}   // R8 hole off, hits
    };

    task automatic cfg_write(input logic [4:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string req, input logic [31:0] addr, input logic wr,
                         input logic e_hit, input logic [2:0] e_row, input logic e_miss);
        acc_addr = addr; acc_write = wr;
        #1;
        n_checks++;
        if (dram_hit !== e_hit || miss !== e_miss || (!e_miss && row_idx !== e_row) ||
            (e_miss && row_idx !== 3'd0)) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0d: got hit=%0d row=%0d miss=%0d, expected hit=%0d row=%0d miss=%0d",
                     req, addr, wr, dram_hit, row_idx, miss, e_hit, e_row, e_miss);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        probe("R1", 32'h0000_0000, 1'b0, 1'b0, 3'd0, 1'b1);
        probe("R1", 32'h000F_0000, 1'b1, 1'b0, 3'd0, 1'b1);

        // Load the main configuration (R10 write path).
        cfg_write(5'd0, 8'h30);
        cfg_write(5'd1, 8'h21);
        cfg_write(5'd2, 8'h03);
        cfg_write(5'd8, 8'd2);  cfg_write(5'd9, 8'd2);
        cfg_write(5'd10, 8'd4); cfg_write(5'd11, 8'd5);
        cfg_write(5'd12, 8'd5); cfg_write(5'd13, 8'd5);
        cfg_write(5'd14, 8'd5); cfg_write(5'd15, 8'd8);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = (i < 2) ? "R5/R4" : (i < 8) ? "R5/R6/R7" : (i < 18) ? "R2/R3" : "R4/R8";
            probe(tag, VECS[i][37:6], VECS[i][5], VECS[i][4], VECS[i][3:1], VECS[i][0]);
        end

        // R10: writes to unmapped indices change nothing.
        cfg_write(5'd7, 8'hFF);
        cfg_write(5'd20, 8'hFF);
        cfg_write(5'd31, 8'hFF);
        probe("R10", 32'h000C_C000, 1'b0, 1'b0, 3'd0, 1'b0);
        probe("R10", 32'h03FF_FFFF, 1'b0, 1'b1, 3'd7, 1'b0);
        probe("R10", 32'h0400_0000, 1'b0, 1'b0, 3'd0, 1'b1);
        probe("R10", 32'h0008_0000, 1'b0, 1'b1, 3'd0, 1'b0);

        // R8: low hole; upper data bits ignored.
        cfg_write(5'd16, 8'hC1);
        probe("R8", 32'h0008_0000, 1'b0, 1'b0, 3'd0, 1'b0);
        probe("R8", 32'h0009_FFFF, 1'b1, 1'b0, 3'd0, 1'b0);
        probe("R8", 32'h000A_0000, 1'b0, 1'b1, 3'd0, 1'b0);
        probe("R8", 32'h0007_FFFF, 1'b1, 1'b1, 3'd0, 1'b0);
        probe("R8", 32'h00F0_0000, 1'b0, 1'b1, 3'd0, 1'b0);

        // R8: high hole.
        cfg_write(5'd16, 8'h02);
        probe("R8", 32'h00F0_0000, 1'b0, 1'b0, 3'd0, 1'b0);
        probe("R8", 32'h00FF_FFFF, 1'b1, 1'b0, 3'd0, 1'b0);
        probe("R8", 32'h00EF_FFFF, 1'b0, 1'b1, 3'd0, 1'b0);
        probe("R8", 32'h0100_0000, 1'b0, 1'b1, 3'd2, 1'b0);
        probe("R8", 32'h0008_0000, 1'b0, 1'b1, 3'd0, 1'b0);

        // R9: reserved code acts as no hole.
        cfg_write(5'd16, 8'h03);
        probe("R9", 32'h00F0_0000, 1'b0, 1'b1, 3'd0, 1'b0);
        probe("R9", 32'h0008_0000, 1'b1, 1'b1, 3'd0, 1'b0);

        // R7/R5: row 0 emptied; row 1 now holds the bottom 16 MB.
        cfg_write(5'd8, 8'd0);
        probe("R7", 32'h0000_0000, 1'b0, 1'b1, 3'd1, 1'b0);
        probe("R5", 32'h00FF_FFFF, 1'b1, 1'b1, 3'd1, 1'b0);

        // R10: new value used right after the storing edge.
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'd15; cfg_wdata = 8'd4;
        acc_addr = 32'h0280_0000; acc_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        probe("R10", 32'h0280_0000, 1'b0, 1'b0, 3'd0, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule